// File: doc/BRIEF.md
# Time-Multiplexed Single-MAC FIR Filter

This block computes a 32-tap finite impulse response filter with one shared multiplier and one accumulator. Each accepted input sample is stored in a circular sample buffer kept in a dual-port RAM. A tap sequencer then steps through the 32 newest samples and the 32 coefficients in lockstep. Each step feeds one sample-coefficient product into a short pipeline. The pipeline ends in a 40-bit accumulator.

The coefficient store has its own write port, so the filter response can be changed at run time without touching the datapath. A sample is offered with a valid/ready handshake. The block takes one sample at a time and holds ready low while that sample's output is being computed. The finished sum appears on the result bus with a one-cycle valid strobe.

Top module: `tmac_fir`

## Requirements
- R1: Each result equals y = sum over k = 0..31 of c[k] * x[n-k]. Here x[n] is the sample just accepted and c[k] is the coefficient stored at coefficient address k, so address 0 weights the newest sample.
- R2: Samples and coefficients are signed two's complement 16-bit values. Each 32-bit product is sign-extended and summed at full precision into a 40-bit two's complement result, with no rounding and no saturation.
- R3: Every result starts from its own first product. No part of an earlier result carries into a later one.
- R4: While fewer than 32 samples have been accepted since reset, taps that reach past the oldest accepted sample contribute zero.
- R5: res_valid is high for exactly one cycle per accepted sample. Counting from the clock edge that accepts the sample, it is high after the 34th edge.
- R6: smp_ready is low from the edge that accepts a sample until the cycle in which that sample's result is valid. A sample offered while smp_ready is low is not taken and has no effect on any later result.
- R7: cw_ready is low while a result is being computed, and a coefficient write takes effect only on an edge where cw_en and cw_ready are both high. A write held pending during a computation does not change that computation's result, and it changes the results of later samples.
- R8: The sample buffer holds 2048 entries and wraps: its write position advances by one for each accepted sample, modulo 2048. Results stay correct after more than 2048 samples.
- R9: After reset, smp_ready and cw_ready are high, res_valid is low, and all coefficients read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Input sample offered |
| smp_ready | output | 1 | Block can take a sample |
| smp_data | input | 16 | Signed input sample |
| cw_en | input | 1 | Coefficient write request |
| cw_ready | output | 1 | Coefficient write can be taken this cycle |
| cw_addr | input | 5 | Coefficient address (tap index) |
| cw_data | input | 16 | Signed coefficient value |
| res_valid | output | 1 | One-cycle strobe marking a finished result |
| res_data | output | 40 | Signed filter output |

## Verification
The assertions assume that the sample and coefficient handshakes are obeyed, so that no sample enters while a computation is in progress. They also assume that reset is applied before the first request. The bench raises smp_valid and cw_en only at falling edges and waits for the matching ready before the capturing edge. When it deliberately holds a request while the block is busy, it drops the request before ready returns, unless the request is a coefficient write that is meant to complete after the result.

// File: rtl/fir_pkg.sv
`timescale 1ns/1ps
package fir_pkg;

  // Per-tap control that travels down the multiply-accumulate pipeline
  typedef struct packed {
    logic first;  // product starts a fresh sum
    logic last;   // product closes the sum
    logic dead;   // tap lies before the oldest stored sample
  } tap_tag_t;

endpackage

// File: rtl/fir_sample_ram.sv
`timescale 1ns/1ps
module fir_sample_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Port A writes, port B reads into a registered output
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fir_coef_mem.sv
`timescale 1ns/1ps
module fir_coef_mem #(
  parameter int CW   = 16,
  parameter int TAPS = 32,
  localparam int KW  = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [KW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic          re,
  input  logic [KW-1:0] raddr,
  output logic [CW-1:0] rdata
);

  logic [CW-1:0] mem [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/fir_addr_gen.sv
`timescale 1ns/1ps
module fir_addr_gen
  import fir_pkg::*;
#(
  parameter int TAPS   = 32,
  parameter int DEPTH  = 2048,
  localparam int AW    = $clog2(DEPTH),
  localparam int KW    = $clog2(TAPS),
  localparam int FW    = $clog2(TAPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          issue,
  output logic [KW-1:0] tap_idx,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output tap_tag_t      tag
);

  logic [AW-1:0] wptr, base;
  logic [FW-1:0] fill;
  logic [KW-1:0] k;
  logic          run;

  // Address k steps behind b on the ring of DEPTH entries
  function automatic logic [AW-1:0] ring_back(logic [AW-1:0] b, logic [KW-1:0] kk);
    logic [AW:0] bx, kx, s;
    bx = {1'b0, b};
    kx = (AW+1)'(kk);
    if (kx > bx) s = bx + (AW+1)'(DEPTH) - kx;
    else         s = bx - kx;
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      base <= '0;
      fill <= '0;
      k    <= '0;
      run  <= 1'b0;
    end else if (start) begin
      base <= wptr;
      wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (fill != FW'(TAPS)) fill <= fill + 1'b1;
      k    <= '0;
      run  <= 1'b1;
    end else if (run) begin
      if (k == KW'(TAPS - 1)) run <= 1'b0;
      k <= k + 1'b1;
    end
  end

  assign issue     = run;
  assign tap_idx   = k;
  assign wr_addr   = wptr;
  assign rd_addr   = ring_back(base, k);
  assign tag.first = (k == '0);
  assign tag.last  = (k == KW'(TAPS - 1));
  assign tag.dead  = (FW'(k) >= fill);

endmodule

// File: rtl/fir_mac.sv
`timescale 1ns/1ps
module fir_mac
  import fir_pkg::*;
#(
  parameter int SW    = 16,
  parameter int CW    = 16,
  parameter int ACC_W = 40,
  localparam int PW   = SW + CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_issue,
  input  tap_tag_t         in_tag,
  input  logic [SW-1:0]    smp_rd,
  input  logic [CW-1:0]    coef_rd,
  output logic             prod_valid,
  output logic             finish,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_data
);

  logic              v1, v2;
  tap_tag_t          t1, t2;
  logic [SW-1:0]     smp_op;
  logic signed [PW-1:0]    prod_q;
  logic signed [ACC_W-1:0] acc_q;

  // Sign-extend a product to accumulator width
  function automatic logic signed [ACC_W-1:0] grow(logic signed [PW-1:0] p);
    return ACC_W'(p);
  endfunction

  // Signed product of the two registered operands
  function automatic logic signed [PW-1:0] mul(logic [SW-1:0] a, logic [CW-1:0] b);
    return PW'($signed(a)) * PW'($signed(b));
  endfunction

  // Stage 1: control aligned with the registered memory outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      t1 <= '0;
    end else begin
      v1 <= in_issue;
      t1 <= in_tag;
    end
  end

  assign smp_op = t1.dead ? '0 : smp_rd;

  // Stage 2: product register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2     <= 1'b0;
      t2     <= '0;
      prod_q <= '0;
    end else begin
      v2 <= v1;
      t2 <= t1;
      if (v1) prod_q <= mul(smp_op, coef_rd);
    end
  end

  assign prod_valid = v2;
  assign finish     = v2 & t2.last;

  // Stage 3: accumulator, loaded by the first product of each sum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= finish;
      if (v2) acc_q <= t2.first ? grow(prod_q) : acc_q + grow(prod_q);
    end
  end

  assign res_data = acc_q;

endmodule

// File: rtl/tmac_fir.sv
`timescale 1ns/1ps
module tmac_fir
  import fir_pkg::*;
#(
  parameter int TAPS  = 32,
  parameter int SW    = 16,
  parameter int CW    = 16,
  parameter int ACC_W = 40,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int KW   = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SW-1:0]    smp_data,
  input  logic             cw_en,
  output logic             cw_ready,
  input  logic [KW-1:0]    cw_addr,
  input  logic [CW-1:0]    cw_data,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_data
);

  logic          busy;
  logic          accept, coef_we, issue, prod_valid, finish;
  logic [KW-1:0] tap_idx;
  logic [AW-1:0] wr_addr, rd_addr;
  tap_tag_t      tag;
  logic [SW-1:0] smp_rd;
  logic [CW-1:0] coef_rd;

  assign smp_ready = !busy;
  assign cw_ready  = !busy;
  assign accept    = smp_valid & smp_ready;
  assign coef_we   = cw_en & cw_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy <= 1'b0;
    else if (accept) busy <= 1'b1;
    else if (finish) busy <= 1'b0;
  end

  fir_addr_gen #(.TAPS(TAPS), .DEPTH(DEPTH)) u_agen (
    .clk(clk), .rst_n(rst_n), .start(accept), .issue(issue),
    .tap_idx(tap_idx), .wr_addr(wr_addr), .rd_addr(rd_addr), .tag(tag)
  );

  fir_sample_ram #(.DW(SW), .DEPTH(DEPTH)) u_sram (
    .clk(clk), .we(accept), .waddr(wr_addr), .wdata(smp_data),
    .re(issue), .raddr(rd_addr), .rdata(smp_rd)
  );

  fir_coef_mem #(.CW(CW), .TAPS(TAPS)) u_cmem (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(cw_addr), .wdata(cw_data),
    .re(issue), .raddr(tap_idx), .rdata(coef_rd)
  );

  fir_mac #(.SW(SW), .CW(CW), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .in_issue(issue), .in_tag(tag),
    .smp_rd(smp_rd), .coef_rd(coef_rd), .prod_valid(prod_valid),
    .finish(finish), .res_valid(res_valid), .res_data(res_data)
  );

endmodule

// File: rtl/fir_chk.sv
`timescale 1ns/1ps
module fir_chk #(
  parameter int TAPS  = 32,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int NW   = $clog2(TAPS + 4) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          issue,
  input logic          coef_we,
  input logic          prod_valid,
  input logic          smp_ready,
  input logic          res_valid,
  input logic [AW-1:0] wptr
);

  logic [NW-1:0] n_issue, n_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_issue <= '0;
      n_lat   <= '1;
    end else if (accept) begin
      n_issue <= '0;
      n_lat   <= '0;
    end else begin
      if (issue) n_issue <= n_issue + 1'b1;
      if (n_lat != '1) n_lat <= n_lat + 1'b1;
    end
  end

  // R1: exactly TAPS reads feed every result
  a_r1_tap_count: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (n_issue == NW'(TAPS)));

  // R5: single-cycle strobe
  a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5: fixed latency from the accepting edge
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (n_lat == NW'(TAPS + 2)));

  // R6: ready drops after an accept and is back with the result
  a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !smp_ready);
  a_r6_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> smp_ready);

  // R7: no coefficient write while taps are read or products are in flight
  a_r7_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |-> (!issue && !prod_valid));

  // R8: write position steps by one modulo DEPTH per accepted sample
  a_r8_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (wptr == (($past(wptr) == AW'(DEPTH - 1)) ? '0 : $past(wptr) + 1'b1)));

endmodule

bind tmac_fir fir_chk #(.TAPS(TAPS), .DEPTH(DEPTH)) u_fir_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .issue(issue),
  .coef_we(coef_we), .prod_valid(prod_valid), .smp_ready(smp_ready),
  .res_valid(res_valid), .wptr(wr_addr)
);

// File: tb/test_tmac_fir.sv
`timescale 1ns/1ps
module test_tmac_fir;
  localparam int TAPS  = 32;
  localparam int DEPTH = 2048;
  localparam int LAT   = 35;       // cyc delta between pre-accept negedge and result negedge
  localparam longint LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid, smp_ready;
  logic [15:0] smp_data;
  logic        cw_en, cw_ready;
  logic [4:0]  cw_addr;
  logic [15:0] cw_data;
  logic        res_valid;
  logic [39:0] res_data;

  always #4 clk = ~clk;  // 125 MHz

  tmac_fir i_tmac_fir (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .cw_en(cw_en), .cw_ready(cw_ready), .cw_addr(cw_addr),
    .cw_data(cw_data), .res_valid(res_valid), .res_data(res_data)
  );

  int     n_chk = 0, n_fail = 0, nsent = 0;
  longint cyc = 0;
  logic signed [15:0] coef_m [TAPS];
  logic signed [15:0] hist [TAPS];
  logic [39:0] exp_q [$];
  longint      t0_q [$];
  string       tag_q [$];
  logic [31:0] lf = 32'hACE1_1234;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [39:0] model();
    longint s = 0;
    for (int k = 0; k < TAPS; k++)
      if (k < nsent) s += longint'(coef_m[k]) * longint'(hist[k]);
    return s[39:0];
  endfunction

  function automatic logic [15:0] rnd();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    return lf[15:0];
  endfunction

  task automatic send(input logic [15:0] d, input string tag);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = d;
    while (!smp_ready) @(negedge clk);
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = d;
    nsent++;
    exp_q.push_back(model());
    t0_q.push_back(cyc);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wcoef(input int a, input logic [15:0] d, input bit blocked);
    @(negedge clk);
    cw_en = 1'b1; cw_addr = a[4:0]; cw_data = d;
    if (blocked) chk(cw_ready == 1'b0, "R7 write held off while busy", longint'(cw_ready), 0);
    while (!cw_ready) @(negedge clk);
    @(posedge clk);
    coef_m[a] = d;
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic load_all(input logic [15:0] d);
    for (int a = 0; a < TAPS; a++) wcoef(a, d, 1'b0);
  endtask

  // Scoreboard monitor
  bit prev_rv = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (res_valid) begin
        chk(!prev_rv, "R5 strobe longer than one cycle", 1, 0);
        if (exp_q.size() == 0) chk(0, "R5 result without a sample", 1, 0);
        else begin
          logic [39:0] e;
          longint t0;
          string tg;
          e = exp_q.pop_front(); t0 = t0_q.pop_front(); tg = tag_q.pop_front();
          chk(res_data === e, tg, longint'($signed(res_data)), longint'($signed(e)));
          chk(cyc - t0 == LAT, "R5 result latency", cyc - t0, LAT);
        end
      end
      prev_rv = res_valid;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc == LIMIT) begin
      chk(0, "watchdog expired", cyc, LIMIT);
      finish_run();
    end
  end

  initial begin
    int n;
    smp_valid = 0; smp_data = '0; cw_en = 0; cw_addr = '0; cw_data = '0;
    for (int k = 0; k < TAPS; k++) begin coef_m[k] = '0; hist[k] = '0; end
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_ready == 1'b1, "R9 smp_ready after reset", longint'(smp_ready), 1);
    chk(cw_ready == 1'b1,  "R9 cw_ready after reset",  longint'(cw_ready), 1);
    chk(res_valid == 1'b0, "R9 res_valid after reset", longint'(res_valid), 0);

    // R9: coefficients are zero after reset
    send(16'd1234, "R9 zero coefficients give zero");

    // R1 / R4: ramp coefficients, impulse through a partly filled buffer
    for (int a = 0; a < TAPS; a++) wcoef(a, 16'(a + 1), 1'b0);
    for (int i = 0; i < 40; i++)
      send((i == 0) ? 16'd1 : 16'd0, (nsent < TAPS - 1) ? "R4 partial fill taps read zero" : "R1 tap ordering");

    // R2: extremes, positive and negative sums
    load_all(16'h8000);
    for (int i = 0; i < TAPS; i++) send(16'h8000, "R2 largest positive sum");
    load_all(16'h7FFF);
    for (int i = 0; i < TAPS; i++) send(16'h8000, "R2 negative sign extension");

    // R3: a zero sum right after a large one
    load_all(16'h0000);
    send(16'h4000, "R3 fresh sum after large result");

    // R6: offer a sample during the busy window and count ready-low cycles
    load_all(16'h0101);
    send(16'd100, "R6 base sample");
    smp_valid = 1'b1; smp_data = 16'h7FFF;
    n = 0;
    while (!smp_ready) begin n++; @(negedge clk); end
    smp_valid = 1'b0;
    chk(n == 34, "R6 ready low window", n, 34);
    send(16'd7, "R6 busy-time sample ignored");

    // R7: coefficient write pending during a computation
    send(16'd200, "R7 in-flight result uses old coefficients");
    wcoef(0, 16'd5000, 1'b1);
    send(16'd300, "R7 later result uses new coefficient");

    // R8: run past the buffer size to wrap the write position
    for (int a = 0; a < TAPS; a++) wcoef(a, rnd(), 1'b0);
    for (int i = 0; i < DEPTH + 60; i++)
      send(rnd(), (nsent >= DEPTH) ? "R8 wrapped buffer" : "R1 random stream");

    repeat (45) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
    finish_run();
  end

endmodule